// File: doc/BRIEF.md
# Paired-Polynomial Number Theoretic Transform Engine

This block runs an in-place radix-2 Cooley-Tukey number theoretic transform over the integers modulo 65537 on two length-N polynomials at once. The two polynomials share one external simple dual-port RAM. Each 34-bit word holds coefficient i of polynomial a in bits [33:17] and coefficient i of polynomial b in bits [16:0]. One read and one write of that word serve both polynomials. Inside the shared datapath, the a-half and the b-half of every butterfly take turns on a single multiplier, a single adder, a single subtractor and a single reducer.

The caller fills the RAM with coefficient i at the bit-reversed address of i. It then pulses `start` and gives the direction on `inverse`. When `done` pulses, the RAM holds the transformed coefficients in natural order. The engine does not compute twiddle factors. Whenever it begins a new twiddle group it pulses `tw_req`, puts out the wanted exponent on `tw_exp` and the direction on `tw_inv`, and takes `tw_val` in that same cycle. The twiddle source must return the root raised to that exponent, where the root is the forward or the inverse primitive N-th root. The inverse direction applies no 1/N scaling.

Top module: `ntt_pair_engine`

## Requirements
- R1: During and right after a synchronous reset, `rd_en`, `wr_en`, `tw_req` and `done` are all 0.
- R2: Suppose input coefficient i of each polynomial sits at address bitrev(i), with a in bits [33:17] and b in bits [16:0], and the twiddle source returns w^e for `tw_exp`=e, where w is a primitive N-th root of unity mod 65537. Then after `done`, address k holds sum over i of c_i·w^(i·k) mod 65537, separately for a and for b.
- R3: A run with `inverse`=1 holds `tw_inv` at 1 while it reads. With the inverse root, a forward run followed by an inverse run, where the spectrum is reloaded at bit-reversed addresses, leaves N·c_i mod 65537 at address i.
- R4: A run makes exactly N-1 `tw_req` pulses, one for each twiddle group and not one for each butterfly. Each pulse falls in a read cycle.
- R5: A run makes exactly log2(N)·N reads and the same number of writes, at most one of each per cycle. Every write goes to the address that was read three cycles earlier.
- R6: `done` is high for exactly one cycle. That cycle comes log2(N)·(N+3)+1 cycles after the cycle in which `start` was sampled, which is one cycle after the last write.
- R7: Every written coefficient lies in [0, 65536]. Inputs equal to 65536 (the value -1) transform correctly, and the a and b halves do not affect each other.
- R8: A `start` pulse that arrives while a run is in progress has no effect. There is still one `done`, with the same latency and correct results.
- R9: The direction is captured when `start` is accepted. Changing `inverse` during a run changes neither `tw_inv` nor the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a transform when the engine is idle |
| inverse | input | 1 | Direction sampled at start (1 = inverse root) |
| rd_en | output | 1 | RAM read strobe, data expected one cycle later |
| rd_addr | output | log2(N) | RAM read address |
| rd_data | input | 34 | RAM read word {a, b} |
| wr_en | output | 1 | RAM write strobe |
| wr_addr | output | log2(N) | RAM write address |
| wr_data | output | 34 | RAM write word {a, b} |
| tw_req | output | 1 | Asks for the twiddle of a new group |
| tw_exp | output | log2(N)-1 | Exponent of the requested twiddle |
| tw_inv | output | 1 | Direction of the requested twiddle |
| tw_val | input | 17 | Twiddle value, valid in the `tw_req` cycle |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The transform is tried on four kinds of input. A pair of unit impulses at different positions sets the a result to a flat spectrum and the b result to the bare powers of the root, so a wrong twiddle exponent or a wrong group order shows up directly. Pseudo-random vectors exercise full-range carries and reductions. Vectors of all 65536 against all zero probe the -1 corner of the reducer and show up any leakage between the two halves. A forward-then-inverse round trip, together with a run disturbed by a second start and a flipped direction, separates a correct twiddle direction and start capture from ones that only look right on a single forward pass.

// File: rtl/ntt_pkg.sv
package ntt_pkg;

    localparam int unsigned MODP    = 65537;
    localparam int unsigned CW      = 17;
    // cycles from a read address to the write of the same address
    localparam int unsigned WR_LAG  = 3;

    typedef logic [CW-1:0] coef_t;

    typedef struct packed {
        coef_t a;
        coef_t b;
    } pair_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_DRAIN,
        ST_DONE
    } seq_state_e;

    // product reduced with 2^16 = -1 (mod p); result in [0, 65536]
    function automatic coef_t mod_mul(input coef_t x, input coef_t y);
        logic [32:0] prod;
        logic [17:0] diff;
        prod = 33'(x) * 33'(y);
        diff = 18'(prod[15:0]) - 18'(prod[32:16]);
        if (diff[17]) diff = diff + 18'(MODP);
        return diff[CW-1:0];
    endfunction

    function automatic coef_t mod_add(input coef_t x, input coef_t y);
        logic [17:0] s;
        s = 18'(x) + 18'(y);
        if (s >= 18'(MODP)) s = s - 18'(MODP);
        return s[CW-1:0];
    endfunction

    function automatic coef_t mod_sub(input coef_t x, input coef_t y);
        logic [17:0] d;
        d = 18'(x) - 18'(y);
        if (d[17]) d = d + 18'(MODP);
        return d[CW-1:0];
    endfunction

endpackage

// File: rtl/ntt_seq_ctrl.sv
module ntt_seq_ctrl
    import ntt_pkg::*;
#(
    parameter int N = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              inverse,
    output logic              rd_en,
    output logic [$clog2(N)-1:0] rd_addr,
    output logic              rd_ph,
    output logic              tw_req,
    output logic [$clog2(N)-2:0] tw_exp,
    output logic              tw_inv,
    output logic              done
);
    localparam int AW = $clog2(N);
    localparam int TW = AW - 1;
    localparam int SW = $clog2(AW);

    seq_state_e    state_q;
    logic [SW-1:0] stage_q;
    logic [TW-1:0] t_q;
    logic          ph_q;
    logic [1:0]    dcnt_q;
    logic          inv_q;

    logic [AW-1:0] t_ext, gmask, grp, jidx, half, u_addr, shamt;

    // butterfly t of a stage: twiddle index j in the top bits, group in the low bits
    always_comb begin
        t_ext  = {1'b0, t_q};
        shamt  = AW'(TW) - AW'(stage_q);
        gmask  = (AW'(1) << shamt) - AW'(1);
        grp    = t_ext & gmask;
        jidx   = t_ext >> shamt;
        half   = AW'(1) << stage_q;
        u_addr = ((grp << stage_q) << 1) | jidx;
    end

    assign rd_en   = (state_q == ST_READ);
    assign rd_addr = ph_q ? (u_addr | half) : u_addr;
    assign rd_ph   = ph_q;
    assign tw_req  = rd_en && !ph_q && (grp == '0);
    assign tw_exp  = TW'(jidx << shamt);
    assign tw_inv  = inv_q;
    assign done    = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            stage_q <= '0;
            t_q     <= '0;
            ph_q    <= 1'b0;
            dcnt_q  <= '0;
            inv_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_READ;
                    stage_q <= '0;
                    t_q     <= '0;
                    ph_q    <= 1'b0;
                    inv_q   <= inverse;
                end
                ST_READ: begin
                    ph_q <= !ph_q;
                    if (ph_q) begin
                        t_q <= t_q + 1'b1;
                        if (t_q == '1) begin
                            state_q <= ST_DRAIN;
                            dcnt_q  <= '0;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (dcnt_q == 2'(WR_LAG - 1)) begin
                        dcnt_q <= '0;
                        if (stage_q == SW'(AW - 1)) begin
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_READ;
                            stage_q <= stage_q + 1'b1;
                        end
                    end else begin
                        dcnt_q <= dcnt_q + 1'b1;
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ntt_pair_datapath.sv
module ntt_pair_datapath
    import ntt_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_ph,
    input  logic          tw_req,
    input  coef_t         tw_val,
    input  pair_t         rd_word,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output pair_t         wr_word
);
    typedef struct packed {
        logic          en;
        logic          ph;
        logic [AW-1:0] addr;
    } tag_t;

    tag_t  dly [WR_LAG+1];
    coef_t w_reg, w_ex, yb_r, a0_r, a1_r, b1_r;
    pair_t x_reg;
    coef_t xo, yo, prod_v, sum_v, dif_v;
    logic  sel_b;

    assign dly[0] = '{en: rd_en, ph: rd_ph, addr: rd_addr};

    always_ff @(posedge clk) begin
        for (int g = 0; g < WR_LAG; g++) begin
            if (rst) dly[g+1] <= '0;
            else     dly[g+1] <= dly[g];
        end
    end

    // second cycle of a butterfly's compute works on the b half
    always_comb begin
        sel_b  = dly[2].ph;
        xo     = sel_b ? x_reg.b : x_reg.a;
        yo     = sel_b ? yb_r    : rd_word.a;
        prod_v = mod_mul(w_ex, yo);
        sum_v  = mod_add(xo, prod_v);
        dif_v  = mod_sub(xo, prod_v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_reg <= '0;
            w_ex  <= '0;
            x_reg <= '0;
            yb_r  <= '0;
            a0_r  <= '0;
            a1_r  <= '0;
            b1_r  <= '0;
        end else begin
            if (tw_req) w_reg <= tw_val;
            if (dly[1].en && !dly[1].ph) begin
                x_reg <= rd_word;
                w_ex  <= w_reg;
            end
            if (dly[2].en && !dly[2].ph) begin
                a0_r <= sum_v;
                a1_r <= dif_v;
                yb_r <= rd_word.b;
            end
            if (dly[2].en && dly[2].ph) b1_r <= dif_v;
        end
    end

    assign wr_en   = dly[WR_LAG].en;
    assign wr_addr = dly[WR_LAG].addr;
    assign wr_word = dly[WR_LAG].ph ? '{a: a1_r, b: b1_r} : '{a: a0_r, b: sum_v};

endmodule

// File: rtl/ntt_pair_engine.sv
module ntt_pair_engine
    import ntt_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 inverse,
    output logic                 rd_en,
    output logic [$clog2(N)-1:0] rd_addr,
    input  logic [33:0]          rd_data,
    output logic                 wr_en,
    output logic [$clog2(N)-1:0] wr_addr,
    output logic [33:0]          wr_data,
    output logic                 tw_req,
    output logic [$clog2(N)-2:0] tw_exp,
    output logic                 tw_inv,
    input  logic [16:0]          tw_val,
    output logic                 done
);
    localparam int AW = $clog2(N);

    logic  rd_ph;
    pair_t rd_word, wr_word;

    assign rd_word = rd_data;
    assign wr_data = wr_word;

    ntt_seq_ctrl #(.N(N)) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .inverse (inverse),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_ph   (rd_ph),
        .tw_req  (tw_req),
        .tw_exp  (tw_exp),
        .tw_inv  (tw_inv),
        .done    (done)
    );

    ntt_pair_datapath #(.AW(AW)) i_dp (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_ph   (rd_ph),
        .tw_req  (tw_req),
        .tw_val  (tw_val),
        .rd_word (rd_word),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_word (wr_word)
    );

endmodule

// File: rtl/ntt_pair_engine_chk.sv
module ntt_pair_engine_chk #(
    parameter int N = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_en,
    input logic [$clog2(N)-1:0] rd_addr,
    input logic                 wr_en,
    input logic [$clog2(N)-1:0] wr_addr,
    input logic [33:0]          wr_data,
    input logic                 tw_req,
    input logic                 tw_inv,
    input logic                 done
);
    // R5
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ($past(rd_en, 3) && wr_addr == $past(rd_addr, 3)));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_after_writes_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rd_en && !wr_en));

    // R4
    tw_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        tw_req |-> rd_en);

    // R7
    wr_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_data[33:17] <= 17'd65536 && wr_data[16:0] <= 17'd65536));

    // R9
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> $stable(tw_inv));

endmodule

bind ntt_pair_engine ntt_pair_engine_chk #(.N(N)) i_chk (.*);

// File: tb/test_ntt_pair_engine.sv
module test_ntt_pair_engine;
    localparam int     N          = 16;
    localparam int     AW         = $clog2(N);
    localparam int     TW         = AW - 1;
    localparam int     CLK_PERIOD = 10;
    localparam longint P          = 65537;
    localparam int     LAT        = AW * (N + 3) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          inverse = 1'b0;
    logic          rd_en, wr_en, tw_req, tw_inv, done;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [33:0]   rd_data = '0;
    logic [33:0]   wr_data;
    logic [TW-1:0] tw_exp;
    logic [16:0]   tw_val;

    logic [33:0]   mem [N];
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [33:0]   ld_data = '0;

    longint wfw, winv;
    longint va [N];
    longint vb [N];
    longint oa [N];
    longint ob [N];

    int n_chk = 0, n_fail = 0;
    int cyc = 0, st_cyc = 0, done_cyc = 0;
    int n_rd, n_wr, n_tw, n_done, addr_err, inv_err;
    logic exp_inv = 1'b0;
    logic          h_en [4];
    logic [AW-1:0] h_ad [4];
    longint seed = 12345;

    always #(CLK_PERIOD/2) clk = ~clk;

    ntt_pair_engine #(.N(N)) i_ntt_pair_engine (
        .clk(clk), .rst(rst), .start(start), .inverse(inverse),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tw_req(tw_req), .tw_exp(tw_exp), .tw_inv(tw_inv), .tw_val(tw_val),
        .done(done)
    );

    function automatic longint modpow(input longint b, input longint e);
        longint r = 1, bb = b % P, ee = e;
        while (ee > 0) begin
            if (ee % 2 == 1) r = (r * bb) % P;
            bb = (bb * bb) % P;
            ee = ee / 2;
        end
        return r;
    endfunction

    function automatic int bitrev(input int i);
        int r = 0;
        for (int k = 0; k < AW; k++) if (((i >> k) & 1) == 1) r |= 1 << (AW - 1 - k);
        return r;
    endfunction

    function automatic longint ref_coef(input int k, input bit use_b, input bit inv);
        longint w = inv ? winv : wfw;
        longint s = 0;
        for (int i = 0; i < N; i++)
            s = (s + (use_b ? vb[i] : va[i]) * modpow(w, (i * k) % N)) % P;
        return s;
    endfunction

    function automatic longint nextrand();
        seed = (seed * 1103515245 + 12345) & 64'h7fffffff;
        return seed % P;
    endfunction

    // twiddle source and RAM model
    always_comb tw_val = 17'(modpow(tw_inv ? winv : wfw, longint'(tw_exp)));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ld_en) mem[ld_addr] <= ld_data;
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end

    always @(negedge clk) begin
        for (int k = 3; k > 0; k--) begin
            h_en[k] = h_en[k-1];
            h_ad[k] = h_ad[k-1];
        end
        h_en[0] = rd_en;
        h_ad[0] = rd_addr;
        if (!rst) begin
            if (rd_en) n_rd++;
            if (wr_en) begin
                n_wr++;
                if (!h_en[3] || h_ad[3] != wr_addr) addr_err++;
            end
            if (tw_req) n_tw++;
            if (rd_en && tw_inv != exp_inv) inv_err++;
            if (done) begin
                n_done++;
                done_cyc = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic load_vals();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_addr = AW'(bitrev(i));
            ld_data = {17'(va[i]), 17'(vb[i])};
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_ntt(input bit inv, input bit disturb);
        int waited = 0;
        n_rd = 0; n_wr = 0; n_tw = 0; n_done = 0; addr_err = 0; inv_err = 0;
        exp_inv = inv;
        @(negedge clk);
        inverse = inv;
        start   = 1'b1;
        st_cyc  = cyc;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (20) @(negedge clk);
            start   = 1'b1;
            inverse = !inv;
            @(negedge clk);
            start = 1'b0;
        end
        while (n_done == 0 && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        repeat (30) @(negedge clk);
        inverse = inv;
        chk(done_cyc - st_cyc == LAT, "R6 done latency", done_cyc - st_cyc, LAT);
        chk(n_done == 1, "R6/R8 done pulse count", n_done, 1);
        chk(n_rd == AW * N, "R5 read count", n_rd, AW * N);
        chk(n_wr == AW * N, "R5 write count", n_wr, AW * N);
        chk(addr_err == 0, "R5 write address lag", addr_err, 0);
        chk(n_tw == N - 1, "R4 twiddle request count", n_tw, N - 1);
        chk(inv_err == 0, "R3/R9 twiddle direction", inv_err, 0);
    endtask

    task automatic check_spectrum(input bit inv, input string req);
        for (int k = 0; k < N; k++) begin
            longint ea = ref_coef(k, 1'b0, inv);
            longint eb = ref_coef(k, 1'b1, inv);
            chk(mem[k] == {17'(ea), 17'(eb)}, req, longint'(mem[k]), (ea << 17) | eb);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!rd_en && !wr_en && !tw_req && !done, "R1 outputs idle in reset",
            {rd_en, wr_en, tw_req, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!rd_en && !wr_en && !tw_req && !done, "R1 outputs idle after reset",
            {rd_en, wr_en, tw_req, done}, 0);
    endtask

    task automatic t_impulse();
        for (int i = 0; i < N; i++) begin
            va[i] = (i == 0) ? 1 : 0;
            vb[i] = (i == 1) ? 1 : 0;
        end
        load_vals();
        run_ntt(1'b0, 1'b0);
        check_spectrum(1'b0, "R2 impulse pair");
    endtask

    task automatic t_mixed();
        for (int i = 0; i < N; i++) begin
            va[i] = nextrand();
            vb[i] = nextrand();
        end
        load_vals();
        run_ntt(1'b0, 1'b0);
        check_spectrum(1'b0, "R2 random vectors");
    endtask

    task automatic t_boundary();
        for (int i = 0; i < N; i++) begin
            va[i] = 65536;
            vb[i] = 0;
        end
        load_vals();
        run_ntt(1'b0, 1'b0);
        check_spectrum(1'b0, "R7 minus-one and zero halves");
    endtask

    task automatic t_roundtrip();
        for (int i = 0; i < N; i++) begin
            oa[i] = nextrand();
            ob[i] = (i % 3 == 0) ? 65536 : nextrand();
            va[i] = oa[i];
            vb[i] = ob[i];
        end
        load_vals();
        run_ntt(1'b0, 1'b0);
        for (int i = 0; i < N; i++) begin
            va[i] = longint'(mem[i][33:17]);
            vb[i] = longint'(mem[i][16:0]);
        end
        load_vals();
        run_ntt(1'b1, 1'b0);
        for (int i = 0; i < N; i++) begin
            longint ea = (oa[i] * N) % P;
            longint eb = (ob[i] * N) % P;
            chk(mem[i] == {17'(ea), 17'(eb)}, "R3 inverse round trip",
                longint'(mem[i]), (ea << 17) | eb);
        end
    endtask

    task automatic t_busy();
        for (int i = 0; i < N; i++) begin
            va[i] = nextrand();
            vb[i] = (i < 4) ? 65536 : i;
        end
        load_vals();
        run_ntt(1'b0, 1'b1);
        check_spectrum(1'b0, "R8/R9 start and direction ignored while busy");
    endtask

    initial begin
        wfw  = modpow(3, 65536 / N);
        winv = modpow(wfw, N - 1);
        for (int k = 0; k < 4; k++) begin
            h_en[k] = 1'b0;
            h_ad[k] = '0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        t_impulse();
        t_mixed();
        t_boundary();
        t_roundtrip();
        t_busy();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule